// File: doc/BRIEF.md
# Sequential Integer Multiply-Divide Unit

This block multiplies and divides 32-bit integers over many clock cycles and keeps its results in two result registers, Hi and Lo. An operation is offered on a valid/ready command port with a function code and two operands. A multiply leaves the 64-bit product split across the pair, with the upper word in Hi and the lower word in Lo. A divide leaves the remainder in Hi and the quotient in Lo. Signed operands are converted to magnitudes before the loop starts, and the signs of the results are fixed on the last iteration. Multiplication is shift-and-add. Division is restoring.

Hi or Lo is read back through a separate request port. Each accepted request produces one response word. The response is also valid/ready. While it is held and `rsp_ready` is low, the unit accepts no new read request. Both request ports hold their ready signal low while an operation runs. A command offered during that time waits at the port and is not taken. A read offered during that time waits and then returns the new result.

Top module: `muldiv_unit`

## Requirements
- R1: Function code 24 is a signed multiply. Hi receives bits 63..32 and Lo receives bits 31..0 of the two's-complement product of `op_a` and `op_b`.
- R2: Function code 25 is an unsigned multiply. The split across Hi and Lo is the same as in R1.
- R3: Function code 26 is a signed divide. Lo receives the quotient, truncated toward zero, so it is negative when the operand signs differ. Hi receives the remainder, which carries the sign of the dividend.
- R4: Function code 27 is an unsigned divide. Lo receives the quotient and Hi receives the remainder.
- R5: A divide by zero, signed or unsigned, completes normally. It leaves Lo at all ones and Hi equal to the original dividend.
- R6: After a command handshake, `busy` is high for exactly 33 cycles: one setup cycle and 32 iteration cycles. Hi and Lo change when `busy` falls. `done` is high for the single cycle after that.
- R7: `op_ready` is low while `busy` is high. A command held on the port during that time is not taken and does not alter Hi or Lo.
- R8: A read request with `rd_hi`=1 returns Hi and with `rd_hi`=0 returns Lo. The value is the one held when the request is accepted, and it is presented on `rsp_data` in the cycle after acceptance.
- R9: `rd_ready` is low while `busy` is high. A read request issued during an operation is answered with that operation's result.
- R10: `ovf` is high only together with `done`, and only after a signed divide of 0x80000000 by 0xFFFFFFFF. That case leaves Lo = 0x80000000 and Hi = 0. Multiplies and unsigned divides never raise `ovf`.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays stable.
- R12: After reset, Hi and Lo are zero, `busy` and `rsp_valid` are low, and `op_ready` is high.
- R13: A command whose code is not 24 to 27 is accepted by the handshake and discarded. It does not raise `busy` and leaves Hi and Lo unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command offered |
| op_ready | output | 1 | Unit idle, so a command can be taken |
| op_fn | input | 6 | Function code |
| op_a | input | 32 | First operand (multiplicand or dividend) |
| op_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when Hi and Lo have been written |
| ovf | output | 1 | Signed divide overflow, valid together with `done` |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request can be taken |
| rd_hi | input | 1 | 1 selects Hi, 0 selects Lo |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Response word |

## Verification
The assertions take for granted that a requester keeps `op_fn`, `op_a` and `op_b` steady for as long as `op_valid` is high. They also take for granted that `rsp_ready` changes only between clock edges. The bench drives every input one time unit after a rising edge and samples at falling edges. It drops `op_valid` before a running operation ends, so a command held during `busy` is never taken by accident. Responses are back-pressured only through `rsp_ready`, and the bench never withdraws a read request before it is accepted.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam logic [5:0] FN_MUL  = 6'd24;
  localparam logic [5:0] FN_MULU = 6'd25;
  localparam logic [5:0] FN_DIV  = 6'd26;
  localparam logic [5:0] FN_DIVU = 6'd27;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } mdu_state_e;

  typedef struct packed {
    logic is_div;
    logic is_signed;
  } mdu_kind_t;
endpackage

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod_next
);
  logic [2*W-1:0] acc_q;
  logic [W-1:0]   mcand_q;
  logic [W:0]     sum;

  // add the multiplicand when the current multiplier bit is set, then shift right one place
  always_comb begin
    sum       = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    prod_next = {sum, acc_q[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= {{W{1'b0}}, mplier};
      mcand_q <= mcand;
    end else if (step) begin
      acc_q   <= prod_next;
    end
  end
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo_next,
  output logic [W-1:0] rem_next
);
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] dvs_q;
  logic [W+1:0] diff;
  logic         fits;

  // trial subtraction of the divisor from the partial remainder extended by the next dividend bit
  always_comb begin
    diff     = {1'b0, rem_q, quo_q[W-1]} - {2'b00, dvs_q};
    fits     = ~diff[W+1];
    rem_next = fits ? diff[W-1:0] : {rem_q[W-2:0], quo_q[W-1]};
    quo_next = {quo_q[W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step) begin
      rem_q <= rem_next;
      quo_q <= quo_next;
    end
  end
endmodule

// File: rtl/mdu_rdport.sv
module mdu_rdport #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         req_valid,
  input  logic         req_hi,
  output logic         req_ready,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  always_comb req_ready = !busy && (!rsp_valid || rsp_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= req_hi ? hi : lo;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [5:0]   op_fn,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic         ovf,
  input  logic         rd_valid,
  output logic         rd_ready,
  input  logic         rd_hi,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [W-1:0]  MIN_NEG = {1'b1, {(W-1){1'b0}}};

  mdu_state_e     st_q;
  mdu_kind_t      kind_q;
  logic [W-1:0]   a_q, b_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   hi_q, lo_q;
  logic           res_neg_q, rem_neg_q, ovf_pend_q;

  logic           known_fn, take;
  logic           neg_a, neg_b;
  logic [W-1:0]   a_mag, b_mag;
  logic           load, step, last_step;
  logic [2*W-1:0] prod_next, prod_fix;
  logic [W-1:0]   quo_next, rem_next, quo_fix, rem_fix;

  always_comb begin
    op_ready  = (st_q == ST_IDLE);
    busy      = (st_q != ST_IDLE);
    known_fn  = (op_fn == FN_MUL) || (op_fn == FN_MULU) ||
                (op_fn == FN_DIV) || (op_fn == FN_DIVU);
    take      = op_valid && op_ready && known_fn;
    neg_a     = kind_q.is_signed && a_q[W-1];
    neg_b     = kind_q.is_signed && b_q[W-1];
    a_mag     = neg_a ? (~a_q + 1'b1) : a_q;
    b_mag     = neg_b ? (~b_q + 1'b1) : b_q;
    load      = (st_q == ST_SETUP);
    step      = (st_q == ST_RUN);
    last_step = step && (cnt_q == LAST);
    prod_fix  = res_neg_q ? (~prod_next + 1'b1) : prod_next;
    quo_fix   = res_neg_q ? (~quo_next + 1'b1) : quo_next;
    rem_fix   = rem_neg_q ? (~rem_next + 1'b1) : rem_next;
  end

  mdu_mul_core #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step && !kind_q.is_div),
    .mcand(a_mag), .mplier(b_mag), .prod_next(prod_next)
  );

  mdu_div_core #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step && kind_q.is_div),
    .dividend(a_mag), .divisor(b_mag), .quo_next(quo_next), .rem_next(rem_next)
  );

  mdu_rdport #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .req_valid(rd_valid), .req_hi(rd_hi), .req_ready(rd_ready),
    .hi(hi_q), .lo(lo_q),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      kind_q     <= '0;
      a_q        <= '0;
      b_q        <= '0;
      cnt_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      res_neg_q  <= 1'b0;
      rem_neg_q  <= 1'b0;
      ovf_pend_q <= 1'b0;
      done       <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      done <= 1'b0;
      ovf  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (take) begin
            st_q             <= ST_SETUP;
            a_q              <= op_a;
            b_q              <= op_b;
            kind_q.is_div    <= op_fn[1];
            kind_q.is_signed <= !op_fn[0];
          end
        end
        ST_SETUP: begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
          // a zero divisor keeps the all-ones quotient uncorrected
          res_neg_q  <= (neg_a ^ neg_b) && !(kind_q.is_div && b_q == '0);
          rem_neg_q  <= neg_a;
          ovf_pend_q <= kind_q.is_div && kind_q.is_signed &&
                        (a_q == MIN_NEG) && (b_q == '1);
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
            ovf  <= ovf_pend_q;
            if (kind_q.is_div) begin
              hi_q <= rem_fix;
              lo_q <= quo_fix;
            end else begin
              hi_q <= prod_fix[2*W-1:W];
              lo_q <= prod_fix[W-1:0];
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic [5:0]   op_fn,
  input logic         busy,
  input logic         done,
  input logic         ovf,
  input logic         rd_ready,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_data
);
  localparam int BCW = $clog2(W + 2) + 1;
  logic [BCW-1:0] busy_cnt;
  logic           sdiv_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      sdiv_seen <= 1'b0;
    end else begin
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
      if (op_valid && op_ready) sdiv_seen <= (op_fn == 6'd26);
    end
  end

  AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_ready);  // R9
  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_ready);  // R7
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_valid && op_ready));  // R7
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));  // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == BCW'(W + 1)));  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (done && sdiv_seen));  // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));  // R11
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_fn(op_fn), .busy(busy), .done(done), .ovf(ovf), .rd_ready(rd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [5:0]   op_fn = '0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         busy, done, ovf;
  logic         rd_valid = 1'b0;
  logic         rd_ready;
  logic         rd_hi = 1'b0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [W-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] m_hi = '0, m_lo = '0;
  logic         m_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  muldiv_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_fn(op_fn), .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .ovf(ovf), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_hi(rd_hi),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every response handshake is compared with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", rsp_data, '0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data === e, t, rsp_data, e);
      end
    end
  end

  task automatic model(input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] sp;
    logic [2*W-1:0] up;
    m_ovf = 1'b0;
    case (fn)
      6'd24: begin
        sp = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        {m_hi, m_lo} = sp;
      end
      6'd25: begin
        up = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        {m_hi, m_lo} = up;
      end
      6'd26: begin
        if (b == '0) begin m_lo = '1; m_hi = a; end
        else if (a == 32'h8000_0000 && b == '1) begin m_lo = a; m_hi = '0; m_ovf = 1'b1; end
        else begin m_lo = $signed(a) / $signed(b); m_hi = $signed(a) % $signed(b); end
      end
      6'd27: begin
        if (b == '0) begin m_lo = '1; m_hi = a; end
        else begin m_lo = a / b; m_hi = a % b; end
      end
      default: ;
    endcase
  endtask

  task automatic start_op(input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk); #1;
    op_valid = 1'b1; op_fn = fn; op_a = a; op_b = b;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    model(fn, a, b);
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == 33, "R6", n, 33);
    chk(done === 1'b1, "R6", done, 1);
    chk(ovf === m_ovf, req, ovf, m_ovf);
  endtask

  task automatic read_req(input logic hi, input string req);
    exp_q.push_back(hi ? m_hi : m_lo);
    tag_q.push_back(req);
    @(posedge clk); #1;
    rd_valid = 1'b1; rd_hi = hi;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic run_op(input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    start_op(fn, a, b);
    wait_done(req);
    read_req(1'b1, req);
    read_req(1'b0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R12", busy, 0);
    chk(rsp_valid === 1'b0, "R12", rsp_valid, 0);
    chk(op_ready === 1'b1, "R12", op_ready, 1);
    read_req(1'b1, "R12");
    read_req(1'b0, "R12");

    run_op(6'd24, 32'hFFFF_FFFD, 32'd7, "R1");
    run_op(6'd24, 32'h8000_0000, 32'h8000_0000, "R1");
    run_op(6'd24, 32'h1234_5678, 32'hFEDC_BA98, "R1");
    run_op(6'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    run_op(6'd25, 32'h0001_0000, 32'h0001_0000, "R2");
    run_op(6'd26, 32'hFFFF_FFF9, 32'd2, "R3");
    run_op(6'd26, 32'd7, 32'hFFFF_FFFE, "R3");
    run_op(6'd26, 32'hFFFF_FF9C, 32'hFFFF_FFF9, "R3");
    run_op(6'd27, 32'd100, 32'd7, "R4");
    run_op(6'd27, 32'hFFFF_FFFF, 32'h8000_0000, "R4");
    run_op(6'd26, 32'hFFFF_FFF0, 32'd0, "R5");
    run_op(6'd27, 32'h0000_1234, 32'd0, "R5");
    run_op(6'd26, 32'h8000_0000, 32'hFFFF_FFFF, "R10");
    run_op(6'd27, 32'h8000_0000, 32'hFFFF_FFFF, "R10");

    // R13: an unknown code handshakes and is dropped
    start_op(6'd16, 32'd5, 32'd5);
    @(negedge clk);
    chk(busy === 1'b0, "R13", busy, 0);
    read_req(1'b1, "R13");
    read_req(1'b0, "R13");

    // R7: a command held during busy is not taken
    start_op(6'd25, 32'd9, 32'd11);
    fork
      wait_done("R7");
      begin
        @(posedge clk); #1;
        op_valid = 1'b1; op_fn = 6'd24; op_a = 32'd3; op_b = 32'd3;
        repeat (5) begin
          @(negedge clk);
          chk(op_ready === 1'b0, "R7", op_ready, 0);
        end
        @(posedge clk); #1;
        op_valid = 1'b0;
      end
    join
    read_req(1'b0, "R7");
    read_req(1'b1, "R7");

    // R9: a read issued during busy waits and returns the new result
    start_op(6'd27, 32'd1000, 32'd33);
    fork
      wait_done("R9");
      begin
        exp_q.push_back(m_lo);
        tag_q.push_back("R9");
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_hi = 1'b0;
        @(negedge clk);
        chk(rd_ready === 1'b0, "R9", rd_ready, 0);
        while (!rd_ready) @(negedge clk);
        @(posedge clk); #1;
        rd_valid = 1'b0;
      end
    join

    // R11: a held response stays put
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    read_req(1'b1, "R11");
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1, "R11", rsp_valid, 1);
      chk(rsp_data === m_hi, "R11", rsp_data, m_hi);
      chk(rd_ready === 1'b0, "R11", rd_ready, 0);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;

    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected below 100000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule